// File: doc/BRIEF.md
# SPI Transmit/Receive FIFO Pair

This block buffers words between a host register interface and an SPI shift engine. It has two 16-entry queues. The transmit queue is filled by host writes. It gives its oldest word to the engine, but it frees that word only when the engine reports a finished transfer. An engine that abandons a transfer part way through therefore finds the same word waiting when it tries again. The receive queue is filled from the engine's shift result each time a transfer finishes, and it is drained by host reads.

Both queues report their fill level as a 4-bit "level minus one" value, with a separate empty flag. A host write to a full transmit queue is acknowledged but flagged as an error, and the word is dropped. A host read from an empty receive queue is acknowledged and flagged the same way. One-cycle event strobes mark these conditions:

- the transmit queue draining to nothing;
- the transmit queue falling to half;
- the engine asking for data that is not there;
- the receive queue becoming full;
- a finished transfer whose result had no room.

Each queue has its own synchronous clear.

Top module: `spi_fifo_pair`

## Requirements
- R1: While `rstN` is low, and after it is released, both queues are empty (`txEmpty`=1, `rxEmpty`=1, both level fields 0). All acknowledge, error and event outputs are 0.
- R2: A host write to a transmit queue holding fewer than 16 words is stored. One clock later `hostWrAck`=1 and `hostWrErr`=0, and the transmit level has grown by one.
- R3: A host write to a full transmit queue produces `hostWrAck`=1 and `hostWrErr`=1 one clock later. The word is discarded and the level is unchanged.
- R4: `engTxData` always shows the oldest stored word, and `engTxValid` is high whenever the transmit queue is not empty. Only `engXferDone` removes a word. `engTxReq` without a completion leaves the queue untouched.
- R5: `engXferDone` stores `engRxData` in the receive queue when it is not full. A host read of a non-empty receive queue gives `hostRdAck`=1 one clock later, with the oldest word on `hostRdData`.
- R6: A host read of an empty receive queue gives `hostRdAck`=1 and `hostRdErr`=1 one clock later, and the level stays at zero.
- R7: `engXferDone` while the receive queue holds 16 words pulses `irqRxOverflow` one clock later. The received word is lost.
- R8: `irqRxFull` pulses for one clock when the receive level rises from 15 to 16.
- R9: `irqTxEmpty` pulses for one clock when a completion removes the last transmit word and no write arrives in the same cycle.
- R10: `irqTxHalf` pulses for one clock when the transmit level falls from 9 to 8.
- R11: `irqTxUnderrun` pulses one clock after `engTxReq` is sampled while the transmit queue is empty.
- R12: Each level field equals the occupancy minus one (0 when empty). The empty flag separates zero entries from one entry, so a full queue reads 15 with the empty flag low.
- R13: `txClear` empties only the transmit queue, and `rxClear` empties only the receive queue. A clear takes priority over any push or pop in the same cycle.
- R14: Accept and reject decisions use the occupancy at the start of the cycle. A write to a full queue that coincides with a completion is rejected while the completion still removes a word. A push and a pop in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txClear | input | 1 | Synchronous clear of the transmit queue |
| rxClear | input | 1 | Synchronous clear of the receive queue |
| hostWrEn | input | 1 | Host write strobe into the transmit queue |
| hostWrData | input | 8 | Host write word |
| hostWrAck | output | 1 | Write acknowledge, one clock after the strobe |
| hostWrErr | output | 1 | Write rejected because the queue was full |
| hostRdEn | input | 1 | Host read strobe from the receive queue |
| hostRdData | output | 8 | Word returned by the read |
| hostRdAck | output | 1 | Read acknowledge, one clock after the strobe |
| hostRdErr | output | 1 | Read rejected because the queue was empty |
| engTxReq | input | 1 | Engine asks for a word to shift out |
| engTxValid | output | 1 | Transmit queue holds a word |
| engTxData | output | 8 | Oldest transmit word |
| engXferDone | input | 1 | Engine finished a transfer |
| engRxData | input | 8 | Shift register result that goes with the completion |
| txCountM1 | output | 4 | Transmit occupancy minus one |
| txEmpty | output | 1 | Transmit queue empty |
| rxCountM1 | output | 4 | Receive occupancy minus one |
| rxEmpty | output | 1 | Receive queue empty |
| irqTxEmpty | output | 1 | Event: last transmit word consumed |
| irqTxHalf | output | 1 | Event: transmit level fell from 9 to 8 |
| irqTxUnderrun | output | 1 | Event: engine request on an empty queue |
| irqRxFull | output | 1 | Event: receive queue became full |
| irqRxOverflow | output | 1 | Event: completion lost for lack of room |

## Verification
A host write and a transfer completion can land in the same cycle, and so can a host read and a completion. The hard case is a write or a completion arriving against a queue that is already full, or a read against a queue that is empty. The directed part forces a write onto a full transmit queue in the same cycle as a completion. It expects an error, a level one below full, and no half or empty event. The random part biases strobe probabilities so that the queues keep hitting both ends while writes, reads and completions overlap. Every cycle is compared against a queue model that decides acceptance from the occupancy at the start of that cycle.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  // Strobes from control to datapath, one set per clock
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txClr;
    logic rxPush;
    logic rxPop;
    logic rxClr;
  } ctlStrobes_t;
endpackage

// File: rtl/spi_fifo_ram.sv
module spi_fifo_ram #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) store[wrPtr] <= wrData;
  end

  assign headData = store[rdPtr];
endmodule

// File: rtl/spi_fifo_datapath.sv
module spi_fifo_datapath
  import spi_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      stb,
  input  logic [WIDTH-1:0] hostWrData,
  input  logic [WIDTH-1:0] engRxData,
  output logic [WIDTH-1:0] engTxData,
  output logic [WIDTH-1:0] hostRdData
);
  logic [WIDTH-1:0] rxHead;

  spi_fifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) txRam (
    .clk(clk), .rstN(rstN), .clr(stb.txClr), .push(stb.txPush),
    .pop(stb.txPop), .wrData(hostWrData), .headData(engTxData)
  );

  spi_fifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) rxRam (
    .clk(clk), .rstN(rstN), .clr(stb.rxClr), .push(stb.rxPush),
    .pop(stb.rxPop), .wrData(engRxData), .headData(rxHead)
  );

  // Read data is registered so that it lines up with the acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          hostRdData <= '0;
    else if (stb.rxPop) hostRdData <= rxHead;
  end
endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     txClear,
  input  logic                     rxClear,
  input  logic                     hostWrEn,
  input  logic                     hostRdEn,
  input  logic                     engTxReq,
  input  logic                     engXferDone,
  output ctlStrobes_t              stb,
  output logic                     hostWrAck,
  output logic                     hostWrErr,
  output logic                     hostRdAck,
  output logic                     hostRdErr,
  output logic                     engTxValid,
  output logic [$clog2(DEPTH)-1:0] txCountM1,
  output logic                     txEmpty,
  output logic [$clog2(DEPTH)-1:0] rxCountM1,
  output logic                     rxEmpty,
  output logic                     irqTxEmpty,
  output logic                     irqTxHalf,
  output logic                     irqTxUnderrun,
  output logic                     irqRxFull,
  output logic                     irqRxOverflow
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_HI  = CNT_W'(DEPTH / 2 + 1);

  logic [CNT_W-1:0] txCount, rxCount, txCountNxt, rxCountNxt;
  logic txFull, rxFull, txNone, rxNone;
  logic wrOk, popOk, rdOk, pushOk;

  assign txFull = (txCount == FULL_CNT);
  assign rxFull = (rxCount == FULL_CNT);
  assign txNone = (txCount == '0);
  assign rxNone = (rxCount == '0);

  // Acceptance uses the occupancy at the start of the cycle
  assign wrOk   = hostWrEn && !txFull;
  assign popOk  = engXferDone && !txNone;
  assign rdOk   = hostRdEn && !rxNone;
  assign pushOk = engXferDone && !rxFull;

  always_comb begin
    stb        = '0;
    stb.txClr  = txClear;
    stb.rxClr  = rxClear;
    stb.txPush = wrOk && !txClear;
    stb.txPop  = popOk && !txClear;
    stb.rxPush = pushOk && !rxClear;
    stb.rxPop  = rdOk;
  end

  always_comb begin
    if (txClear) txCountNxt = '0;
    else         txCountNxt = txCount + CNT_W'(wrOk) - CNT_W'(popOk);
    if (rxClear) rxCountNxt = '0;
    else         rxCountNxt = rxCount + CNT_W'(pushOk) - CNT_W'(rdOk);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCount       <= '0;
      rxCount       <= '0;
      hostWrAck     <= 1'b0;
      hostWrErr     <= 1'b0;
      hostRdAck     <= 1'b0;
      hostRdErr     <= 1'b0;
      irqTxEmpty    <= 1'b0;
      irqTxHalf     <= 1'b0;
      irqTxUnderrun <= 1'b0;
      irqRxFull     <= 1'b0;
      irqRxOverflow <= 1'b0;
    end else begin
      txCount       <= txCountNxt;
      rxCount       <= rxCountNxt;
      hostWrAck     <= hostWrEn;
      hostWrErr     <= hostWrEn && txFull;
      hostRdAck     <= hostRdEn;
      hostRdErr     <= hostRdEn && rxNone;
      irqTxEmpty    <= !txClear && popOk && !wrOk && (txCount == CNT_W'(1));
      irqTxHalf     <= !txClear && popOk && !wrOk && (txCount == HALF_HI);
      irqTxUnderrun <= engTxReq && txNone;
      irqRxFull     <= !rxClear && pushOk && !rdOk && (rxCount == FULL_CNT - 1'b1);
      irqRxOverflow <= engXferDone && rxFull;
    end
  end

  assign txEmpty    = txNone;
  assign rxEmpty    = rxNone;
  assign engTxValid = !txNone;
  assign txCountM1  = txNone ? '0 : PTR_W'(txCount - 1'b1);
  assign rxCountM1  = rxNone ? '0 : PTR_W'(rxCount - 1'b1);

  // Occupancy never exceeds the depth
  assert_tx_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= FULL_CNT);
  assert_rx_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= FULL_CNT);
  // A request without completion never frees a word
  assert_abort_keeps_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!engXferDone && !hostWrEn && !txClear) |=> $stable(txCount));
  // Overflowing completion leaves the queue full
  assert_overflow_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    (engXferDone && rxFull && !hostRdEn && !rxClear) |=> rxFull);
  assert_empty_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqTxEmpty |-> txNone);
  assert_half_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqTxHalf |-> (txCount == HALF_HI - 1'b1));
  assert_full_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqRxFull |-> rxFull);
  assert_clear_tx_R13: assert property (@(posedge clk) disable iff (!rstN)
    txClear |=> txNone);
  assert_wr_full_R14: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && txFull && engXferDone && !txClear) |=> (txCount == FULL_CNT - 1'b1));
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
  import spi_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     txClear,
  input  logic                     rxClear,
  input  logic                     hostWrEn,
  input  logic [WIDTH-1:0]         hostWrData,
  output logic                     hostWrAck,
  output logic                     hostWrErr,
  input  logic                     hostRdEn,
  output logic [WIDTH-1:0]         hostRdData,
  output logic                     hostRdAck,
  output logic                     hostRdErr,
  input  logic                     engTxReq,
  output logic                     engTxValid,
  output logic [WIDTH-1:0]         engTxData,
  input  logic                     engXferDone,
  input  logic [WIDTH-1:0]         engRxData,
  output logic [$clog2(DEPTH)-1:0] txCountM1,
  output logic                     txEmpty,
  output logic [$clog2(DEPTH)-1:0] rxCountM1,
  output logic                     rxEmpty,
  output logic                     irqTxEmpty,
  output logic                     irqTxHalf,
  output logic                     irqTxUnderrun,
  output logic                     irqRxFull,
  output logic                     irqRxOverflow
);
  ctlStrobes_t stb;

  spi_fifo_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .txClear(txClear), .rxClear(rxClear),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .engTxReq(engTxReq),
    .engXferDone(engXferDone), .stb(stb),
    .hostWrAck(hostWrAck), .hostWrErr(hostWrErr),
    .hostRdAck(hostRdAck), .hostRdErr(hostRdErr),
    .engTxValid(engTxValid),
    .txCountM1(txCountM1), .txEmpty(txEmpty),
    .rxCountM1(rxCountM1), .rxEmpty(rxEmpty),
    .irqTxEmpty(irqTxEmpty), .irqTxHalf(irqTxHalf),
    .irqTxUnderrun(irqTxUnderrun), .irqRxFull(irqRxFull),
    .irqRxOverflow(irqRxOverflow)
  );

  spi_fifo_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWrData(hostWrData),
    .engRxData(engRxData), .engTxData(engTxData), .hostRdData(hostRdData)
  );
endmodule

// File: tb/tb_spi_fifo_pair.sv
module tb_spi_fifo_pair;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txClear = 0, rxClear = 0, hostWrEn = 0, hostRdEn = 0;
  logic engTxReq = 0, engXferDone = 0;
  logic [7:0] hostWrData = 0, engRxData = 0;
  logic hostWrAck, hostWrErr, hostRdAck, hostRdErr, engTxValid;
  logic [7:0] hostRdData, engTxData;
  logic [3:0] txCountM1, rxCountM1;
  logic txEmpty, rxEmpty, irqTxEmpty, irqTxHalf, irqTxUnderrun, irqRxFull, irqRxOverflow;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int txQ[$];
  int rxQ[$];

  always #2 clk = ~clk;

  spi_fifo_pair dut (
    .clk(clk), .rstN(rstN), .txClear(txClear), .rxClear(rxClear),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostWrAck(hostWrAck),
    .hostWrErr(hostWrErr), .hostRdEn(hostRdEn), .hostRdData(hostRdData),
    .hostRdAck(hostRdAck), .hostRdErr(hostRdErr), .engTxReq(engTxReq),
    .engTxValid(engTxValid), .engTxData(engTxData), .engXferDone(engXferDone),
    .engRxData(engRxData), .txCountM1(txCountM1), .txEmpty(txEmpty),
    .rxCountM1(rxCountM1), .rxEmpty(rxEmpty), .irqTxEmpty(irqTxEmpty),
    .irqTxHalf(irqTxHalf), .irqTxUnderrun(irqTxUnderrun),
    .irqRxFull(irqRxFull), .irqRxOverflow(irqRxOverflow)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int levelM1(int n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  // One clock: drive at falling edge, predict from model, compare after rising edge
  task automatic step(bit wr, int wd, bit rd, bit req, bit done, int rxw, bit tclr, bit rclr);
    int txN, rxN, expRd;
    bit wrOk, popOk, rdOk, pushOk;
    bit eEmpty, eHalf, eUnder, eFull, eOvf;
    @(negedge clk);
    hostWrEn = wr; hostWrData = wd[7:0]; hostRdEn = rd; engTxReq = req;
    engXferDone = done; engRxData = rxw[7:0]; txClear = tclr; rxClear = rclr;
    txN = txQ.size(); rxN = rxQ.size();
    wrOk = wr && txN < DEPTH;
    popOk = done && txN > 0;
    rdOk = rd && rxN > 0;
    pushOk = done && rxN < DEPTH;
    expRd = rdOk ? rxQ[0] : -1;
    eEmpty = !tclr && popOk && !wrOk && txN == 1;
    eHalf = !tclr && popOk && !wrOk && txN == DEPTH / 2 + 1;
    eUnder = req && txN == 0;
    eFull = !rclr && pushOk && !rdOk && rxN == DEPTH - 1;
    eOvf = done && rxN == DEPTH;
    if (tclr) txQ.delete();
    else begin
      if (popOk) void'(txQ.pop_front());
      if (wrOk) txQ.push_back(wd & 8'hff);
    end
    if (rclr) rxQ.delete();
    else begin
      if (rdOk) void'(rxQ.pop_front());
      if (pushOk) rxQ.push_back(rxw & 8'hff);
    end
    @(posedge clk);
    #1;
    chk("R2", "hostWrAck", hostWrAck, wr);
    chk("R3", "hostWrErr", hostWrErr, wr && !wrOk);
    chk("R5", "hostRdAck", hostRdAck, rd);
    chk("R6", "hostRdErr", hostRdErr, rd && !rdOk);
    if (rdOk) chk("R5", "hostRdData", hostRdData, expRd);
    chk("R12", "txCountM1", txCountM1, levelM1(txQ.size()));
    chk("R12", "txEmpty", txEmpty, txQ.size() == 0);
    chk("R12", "rxCountM1", rxCountM1, levelM1(rxQ.size()));
    chk("R12", "rxEmpty", rxEmpty, rxQ.size() == 0);
    chk("R4", "engTxValid", engTxValid, txQ.size() > 0);
    if (txQ.size() > 0) chk("R4", "engTxData", engTxData, txQ[0]);
    chk("R9", "irqTxEmpty", irqTxEmpty, eEmpty);
    chk("R10", "irqTxHalf", irqTxHalf, eHalf);
    chk("R11", "irqTxUnderrun", irqTxUnderrun, eUnder);
    chk("R8", "irqRxFull", irqRxFull, eFull);
    chk("R7", "irqRxOverflow", irqRxOverflow, eOvf);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(posedge clk);
    #1;
    // R1: state during reset
    chk("R1", "txEmpty in reset", txEmpty, 1);
    chk("R1", "rxEmpty in reset", rxEmpty, 1);
    chk("R1", "txCountM1 in reset", txCountM1, 0);
    chk("R1", "acks in reset", {hostWrAck, hostRdAck, hostWrErr, hostRdErr}, 0);
    chk("R1", "irqs in reset", {irqTxEmpty, irqTxHalf, irqTxUnderrun, irqRxFull, irqRxOverflow}, 0);
    @(negedge clk);
    rstN = 1'b1;
    idle();

    // Fill the transmit queue (R2), then write into full (R3)
    for (int i = 0; i < DEPTH; i++) step(1, 8'h10 + i, 0, 0, 0, 0, 0, 0);
    chk("R12", "full txCountM1", txCountM1, 15);
    step(1, 8'hee, 0, 0, 0, 0, 0, 0);
    chk("R3", "write on full keeps level", txCountM1, 15);
    // R14: write on full coinciding with completion
    step(1, 8'hdd, 0, 0, 1, 8'h80, 0, 0);
    chk("R14", "rejected write, pop applied", txCountM1, 14);
    chk("R14", "write error", hostWrErr, 1);
    // R4: requests without completion (aborts) keep the data
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R4", "abort keeps level", txCountM1, 14);
    chk("R4", "abort keeps head", engTxData, 8'h11);
    // Drain with completions: half (R10), rx full (R8), tx empty (R9)
    for (int i = 0; i < DEPTH - 1; i++) step(0, 0, 0, 1, 1, 8'h81 + i, 0, 0);
    chk("R9", "tx drained", txEmpty, 1);
    chk("R8", "rx full level", rxCountM1, 15);
    // R11 underrun
    step(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R11", "underrun pulse", irqTxUnderrun, 1);
    // R7 overflow
    step(0, 0, 0, 0, 1, 8'h55, 0, 0);
    chk("R7", "overflow pulse", irqRxOverflow, 1);
    // Read everything, then read empty (R5, R6)
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R6", "read on empty error", hostRdErr, 1);
    // R13 independent clears
    for (int i = 0; i < 5; i++) step(1, 8'h40 + i, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 8'h77, 0, 0);
    step(0, 0, 0, 0, 1, 8'h78, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R13", "tx cleared", txEmpty, 1);
    chk("R13", "rx untouched", rxCountM1, 1);
    step(1, 8'h99, 0, 0, 0, 0, 0, 1);
    chk("R13", "rx cleared", rxEmpty, 1);
    chk("R13", "tx untouched", txCountM1, 0);

    // Constrained random phases with shifting bias
    for (int ph = 0; ph < 6; ph++) begin
      int pw, pr, pd;
      pw = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 30 : 55;
      pd = (ph % 3 == 0) ? 30 : (ph % 3 == 1) ? 70 : 50;
      pr = (ph % 2 == 0) ? 20 : 70;
      for (int i = 0; i < 500; i++)
        step(($urandom % 100) < pw, $urandom % 256, ($urandom % 100) < pr,
             ($urandom % 100) < 40, ($urandom % 100) < pd, $urandom % 256,
             ($urandom % 200) == 0, ($urandom % 200) == 0);
    end
    idle();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule